// File: doc/BRIEF.md
# Dual-level priority encoder

This block looks at an 8-bit request vector and names two winners at once. The first winner is the asserted request with the highest priority. The second winner is the asserted request that ranks next below the first. Each winner has its own valid flag. Bit 7 ranks above all other bits and bit 0 ranks below all other bits.

The block has no clock and no state. Every output follows the request vector through combinational logic only. A typical use is an arbiter that must serve two requesters in one step, for example a dual-issue slot picker. In such a picker the first grant takes the first code and the second grant takes the second code.

The second winner is found in two steps. The first winner's request bit is removed from the vector. The same top-finding logic then runs again on what is left.

Top module: `dpe_dual_encoder`

## Requirements
- R1: `first_vld_o` is 1 exactly when at least one bit of `request_i` is 1.
- R2: When `first_vld_o` is 1, `first_idx_o` is the index of the highest set bit of `request_i`. Bit 7 has the highest priority, and the index is a plain unsigned binary number from 0 to 7.
- R3: `second_vld_o` is 1 exactly when at least two bits of `request_i` are 1.
- R4: When `second_vld_o` is 1, `second_idx_o` is the index of the highest set bit of `request_i` once the bit at `first_idx_o` is cleared.
- R5: When `request_i` is all zeros, `first_idx_o` and `second_idx_o` are both 3'b000, and `first_vld_o` and `second_vld_o` are both 0.
- R6: When exactly one bit of `request_i` is 1, `second_idx_o` is 3'b000 and `second_vld_o` is 0.
- R7: Whenever `second_vld_o` is 1, `second_idx_o` is strictly less than `first_idx_o`. The outputs take their new values after a change of `request_i` with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| request_i | input | 8 | Request vector; bit 7 has the highest priority |
| first_idx_o | output | 3 | Index of the highest-priority asserted request |
| first_vld_o | output | 1 | At least one request is asserted |
| second_idx_o | output | 3 | Index of the next asserted request below the first |
| second_vld_o | output | 1 | At least two requests are asserted |

## Verification
The hardest case to bring about is a second winner that depends on masking across a long gap. An example is bit 7 together with bit 0 only: the mask must clear the top bit, and the second search must then pass over every empty bit in between. The same holds for the step from two requests down to one, where `second_vld_o` must drop while `first_idx_o` stays the same.

The stimulus covers these cases in three ways:
- It sweeps all 256 request patterns in order.
- It adds directed pairs and single bits at the two ends of the vector.
- It finishes with seeded random patterns. In this phase each pattern arrives straight after an unrelated one, so the outputs must settle from arbitrary earlier values.

// File: rtl/dpe_pkg.sv
// Package: shared widths and types for the dual-level priority encoder.
// Assumes the request vector width is a power of two, so that every index
// code is reachable.
package dpe_pkg;
    localparam int unsigned REQ_W = 8;
    localparam int unsigned IDX_W = $clog2(REQ_W);

    typedef logic [REQ_W-1:0] req_vec_t;
    typedef logic [IDX_W-1:0] req_idx_t;
endpackage

// File: rtl/dpe_pick_top.sv
// Module: dpe_pick_top
// Finds the highest set bit of a request vector and returns it one-hot,
// together with a flag that says whether any bit was set.
// Assumes the MSB has the highest priority. The logic is purely combinational.
module dpe_pick_top #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] req_i,
    output logic [WIDTH-1:0] grant_o,
    output logic             any_o
);
    // Purpose: walk from the MSB down; a bit wins only if no higher bit is set.
    always_comb begin
        logic seen;
        seen    = 1'b0;
        grant_o = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            grant_o[i] = req_i[i] & ~seen;
            seen       = seen | req_i[i];
        end
        any_o = seen;
    end
endmodule

// File: rtl/dpe_onehot_to_bin.sv
// Module: dpe_onehot_to_bin
// Converts a one-hot (or all-zero) vector into its binary index.
// Assumes at most one bit is set. An all-zero input gives index zero.
module dpe_onehot_to_bin #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] onehot_i,
    output logic [IDX_W-1:0] idx_o
);
    // Returns the set of one-hot positions whose index has bit b set.
    function automatic logic [WIDTH-1:0] sel_mask(input int unsigned b);
        logic [WIDTH-1:0] m;
        m = '0;
        for (int unsigned i = 0; i < WIDTH; i++) begin
            m[i] = ((i >> b) & 1) == 1;
        end
        return m;
    endfunction

    // Each output bit is the OR of the one-hot positions that carry it.
    for (genvar b = 0; b < IDX_W; b++) begin : g_bit
        localparam logic [WIDTH-1:0] SEL = sel_mask(b);
        assign idx_o[b] = |(onehot_i & SEL);
    end
endmodule

// File: rtl/dpe_dual_encoder.sv
// Module: dpe_dual_encoder (top)
// Reports the highest and the second-highest asserted request, each with its
// own valid flag. The second search runs on the request vector with the first
// winner's bit cleared.
// Assumes bit REQ_W-1 has the highest priority. There is no clock and no state.
module dpe_dual_encoder
    import dpe_pkg::*;
(
    input  logic [REQ_W-1:0] request_i,
    output logic [IDX_W-1:0] first_idx_o,
    output logic             first_vld_o,
    output logic [IDX_W-1:0] second_idx_o,
    output logic             second_vld_o
);
    req_vec_t grant_top;
    req_vec_t remain;
    req_vec_t grant_next;

    // First level: find the top request.
    dpe_pick_top #(.WIDTH(REQ_W)) u_pick_first (
        .req_i   (request_i),
        .grant_o (grant_top),
        .any_o   (first_vld_o)
    );

    // Purpose: clear the winning bit so that the next search sees only lower requests.
    always_comb begin
        remain = request_i & ~grant_top;
    end

    // Second level: find the top of what remains.
    dpe_pick_top #(.WIDTH(REQ_W)) u_pick_second (
        .req_i   (remain),
        .grant_o (grant_next),
        .any_o   (second_vld_o)
    );

    dpe_onehot_to_bin #(.WIDTH(REQ_W), .IDX_W(IDX_W)) u_enc_first (
        .onehot_i (grant_top),
        .idx_o    (first_idx_o)
    );

    dpe_onehot_to_bin #(.WIDTH(REQ_W), .IDX_W(IDX_W)) u_enc_second (
        .onehot_i (grant_next),
        .idx_o    (second_idx_o)
    );
endmodule

// File: rtl/dpe_dual_encoder_chk.sv
// Module: dpe_dual_encoder_chk
// Property checker for dpe_dual_encoder. It relates the outputs to the request
// vector with immediate assertions, because the block has no clock.
// It is attached to the top module through the bind statement at the end of
// this file.
module dpe_dual_encoder_chk
    import dpe_pkg::*;
(
    input logic [REQ_W-1:0] request_i,
    input logic [IDX_W-1:0] first_idx_o,
    input logic             first_vld_o,
    input logic [IDX_W-1:0] second_idx_o,
    input logic             second_vld_o
);
    // Purpose: check every output relation whenever an input or output moves.
    always_comb begin
        p_first_vld_r1: assert (first_vld_o == (request_i != '0))
            else $error("first valid flag does not match the request vector");
        p_first_top_r2: assert (!first_vld_o || ((request_i >> first_idx_o) == 1))
            else $error("first index is not the highest set bit");
        p_second_vld_r3: assert (second_vld_o == ($countones(request_i) >= 2))
            else $error("second valid flag does not match the request count");
        p_second_set_r4: assert (!second_vld_o || request_i[second_idx_o])
            else $error("second index points at an idle request");
        p_idle_r5: assert (first_vld_o || (first_idx_o == '0 && second_idx_o == '0 && !second_vld_o))
            else $error("idle outputs are not all zero");
        p_single_r6: assert ($countones(request_i) != 1 || (second_idx_o == '0 && !second_vld_o))
            else $error("second output active with a single request");
        p_order_r7: assert (!second_vld_o || (second_idx_o < first_idx_o))
            else $error("second index not below first index");
    end
endmodule

bind dpe_dual_encoder dpe_dual_encoder_chk u_chk (
    .request_i    (request_i),
    .first_idx_o  (first_idx_o),
    .first_vld_o  (first_vld_o),
    .second_idx_o (second_idx_o),
    .second_vld_o (second_vld_o)
);

// File: tb/dpe_dual_encoder_tb.sv
// Bench for dpe_dual_encoder. It runs an exhaustive sweep, then directed
// corner cases, then seeded random patterns. Every result is compared with a
// reference model computed in bench functions.
module dpe_dual_encoder_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] request;
    logic [2:0] first_idx;
    logic       first_vld;
    logic [2:0] second_idx;
    logic       second_vld;
    int         n_checks = 0;
    int         n_errors = 0;
    int         cycles = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    dpe_dual_encoder u_dut (
        .request_i    (request),
        .first_idx_o  (first_idx),
        .first_vld_o  (first_vld),
        .second_idx_o (second_idx),
        .second_vld_o (second_vld)
    );

    // Index of the highest set bit, or 0 when no bit is set.
    function automatic int ref_top(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) if (v[i]) return i;
        return 0;
    endfunction

    // Number of set bits.
    function automatic int ref_count(input logic [7:0] v);
        int n = 0;
        for (int i = 0; i < 8; i++) if (v[i]) n++;
        return n;
    endfunction

    // Highest set bit once the top bit is cleared, or 0 when fewer than two bits are set.
    function automatic int ref_next(input logic [7:0] v);
        logic [7:0] m;
        m = v;
        if (ref_count(v) < 2) return 0;
        m[ref_top(v)] = 1'b0;
        return ref_top(m);
    endfunction

    task automatic check(input string tag, input logic [7:0] v, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s request=%08b actual=%0d expected=%0d", tag, v, act, exp);
        end
    endtask

    // Drive a pattern after a rising edge, then compare at the following falling edge.
    task automatic apply(input logic [7:0] v);
        int cnt;
        @(posedge clk);
        request = v;
        @(negedge clk);
        cnt = ref_count(v);
        check("R1", v, int'(first_vld), int'(cnt >= 1));
        check("R2", v, int'(first_idx), ref_top(v));
        check("R3", v, int'(second_vld), int'(cnt >= 2));
        check("R4", v, int'(second_idx), ref_next(v));
        if (second_vld) check("R7", v, int'(second_idx < first_idx), 1);
        if (cnt == 1) check("R6", v, int'({second_vld, second_idx}), 0);
    endtask

    // Watchdog: ends a hung run as a failed check.
    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_errors++;
                n_checks++;
                $display("FAIL watchdog expired after %0d cycles", cycles);
                $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] r;
        request = 8'h00;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R5: with an all-zero request every output is zero.
        check("R5", request, int'({first_vld, first_idx, second_vld, second_idx}), 0);

        // R7: a change of the request is seen without waiting for any clock edge.
        request = 8'b1000_0001;
        #1;
        check("R7", request, int'(second_idx), 0);
        check("R7", request, int'(first_idx), 7);

        // Exhaustive sweep of all request patterns.
        for (int p = 0; p < 256; p++) apply(8'(p));

        // Directed corner cases: end bits, single bits, wide gaps, and a return to idle.
        apply(8'b1000_0001);
        apply(8'b1000_0000);
        apply(8'b0000_0001);
        apply(8'b0000_0011);
        apply(8'b1100_0000);
        apply(8'b1111_1111);
        apply(8'b0000_0000);
        check("R5", request, int'({first_vld, first_idx, second_vld, second_idx}), 0);

        // Seeded random patterns.
        r = $urandom(32'h0005_EED1);
        for (int k = 0; k < 300; k++) begin
            r = $urandom;
            apply(r[7:0]);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule